// File: doc/BRIEF.md
# LED Breathing PWM Controller

This block drives an LED with a pulse-width modulated signal whose duty value ramps slowly up and down, so the LED appears to breathe. A free-running period counter advances on each tick of an enable strobe. The LED output is high while that count is below the current duty value. The period is 256, 128 or 64 ticks long, chosen by a size select.

The duty value moves through four phases: rise, hold high, fall and hold low. During a ramp it moves by a step size and waits a number of periods between moves. Both values are read from eight packed segment fields. In symmetric mode the segment is picked by the top three bits of the duty value, counted within the active period size. In asymmetric mode the rising ramp uses segments 0 to 3 and the falling ramp uses segments 4 to 7. Steps are clamped at the programmed maximum and minimum. The hold phases last a programmed number of whole periods.

Duty changes take effect only at a period wraparound, so no period is ever cut short. Dropping the run input clears all state. When run returns, the duty value starts again from zero and rises.

Top module: `led_breath_pwm`

## Requirements
- R1: The period counter advances on each cycle with `tick` high and returns to 0 after reaching its top value. The top value is 255 for `size_sel`=0, 127 for `size_sel`=1, and 63 for `size_sel`=2 or 3. A wrap is a tick taken while the count equals the top value.
- R2: `led` is high exactly when the period count is strictly less than the duty value.
- R3: While `rst_n` is low or `run` is low, the counter, the duty value, the interval and hold counters are cleared, and the phase is set to rise. This drives `led` low.
- R4: In a ramp phase, the interval counter is checked at each wrap. If it is nonzero, it is decremented. If it is zero, the duty value moves by the segment's step and the counter is reloaded from the segment's interval field. The first move therefore happens at the first wrap after a ramp phase is entered.
- R5: A rising move that would reach or pass `duty_max` sets the duty value to `duty_max`. The block then holds for `hold_hi` wraps before falling. If `hold_hi` is 0, the fall phase starts at once.
- R6: A falling move that would reach or pass `duty_min` sets the duty value to `duty_min`. The block then holds for `hold_lo` wraps before rising again. If `hold_lo` is 0, the rise phase starts at once.
- R7: With `asym`=0, the segment index is duty bits [7:5], [6:4] or [5:3] for the 8-, 7- or 6-bit period size. Segment k's step is `step_tbl[k*STEP_W +: STEP_W]` and its interval is `intv_tbl[k*INT_W +: INT_W]`.
- R8: With `asym`=1, the segment index is {falling, top two bits of the R7 field}. The falling bit is 1 only in the fall phase.
- R9: The duty value changes only at a wrap or on a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | PWM tick enable |
| run | input | 1 | Enable; low clears all state |
| size_sel | input | 2 | Period size: 0 = 256, 1 = 128, 2 or 3 = 64 ticks |
| duty_min | input | 8 | Lowest duty value of the fall ramp |
| duty_max | input | 8 | Highest duty value of the rise ramp |
| hold_hi | input | HOLD_W | Periods to hold at the maximum |
| hold_lo | input | HOLD_W | Periods to hold at the minimum |
| step_tbl | input | 8*STEP_W | Eight packed step sizes |
| intv_tbl | input | 8*INT_W | Eight packed update intervals, in extra periods |
| asym | input | 1 | Asymmetric segment split |
| led | output | 1 | LED drive |

## Verification
The bench builds the block with STEP_W=8, INT_W=3 and HOLD_W=4. Short intervals and holds let each run pass through many complete rise, hold, fall and hold cycles in every period size. The wide step fields make it possible to hit both clamps from far away, including when a single step would overshoot. They also allow steps large enough that a ramp crosses several segments, so both the symmetric and the asymmetric segment selection are exercised.

// File: rtl/led_breath_pwm.sv
module led_breath_pwm #(
  parameter int STEP_W = 8,
  parameter int INT_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                run,
  input  logic [1:0]          size_sel,
  input  logic [7:0]          duty_min,
  input  logic [7:0]          duty_max,
  input  logic [HOLD_W-1:0]   hold_hi,
  input  logic [HOLD_W-1:0]   hold_lo,
  input  logic [8*STEP_W-1:0] step_tbl,
  input  logic [8*INT_W-1:0]  intv_tbl,
  input  logic                asym,
  output logic                led
);
  localparam int SW = 9;

  typedef enum logic [1:0] {RISE, HOLD_HI, FALL, HOLD_LO} phase_t;

  phase_t            ph;
  logic [7:0]        cnt, duty, top;
  logic [INT_W-1:0]  dly;
  logic [HOLD_W-1:0] hcnt;
  logic [2:0]        up3, seg;
  logic [STEP_W-1:0] step;
  logic [INT_W-1:0]  intv;
  logic [SW-1:0]     sum, floor_lim;
  logic              wrap, rise_hit, fall_hit;

  assign top  = (size_sel == 2'd0) ? 8'd255 : (size_sel == 2'd1) ? 8'd127 : 8'd63;
  assign wrap = tick && (cnt == top);
  assign led  = cnt < duty;

  always_comb begin
    case (size_sel)
      2'd0:    up3 = duty[7:5];
      2'd1:    up3 = duty[6:4];
      default: up3 = duty[5:3];
    endcase
  end

  assign seg       = asym ? {ph == FALL, up3[2:1]} : up3;
  assign step      = step_tbl[seg*STEP_W +: STEP_W];
  assign intv      = intv_tbl[seg*INT_W +: INT_W];
  assign sum       = SW'(duty) + SW'(step);
  assign floor_lim = SW'(duty_min) + SW'(step);
  assign rise_hit  = sum >= SW'(duty_max);
  assign fall_hit  = SW'(duty) <= floor_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; duty <= '0; dly <= '0; hcnt <= '0; ph <= RISE;
    end else if (!run) begin
      cnt <= '0; duty <= '0; dly <= '0; hcnt <= '0; ph <= RISE;
    end else if (tick) begin
      cnt <= wrap ? 8'd0 : cnt + 8'd1;
      if (wrap) begin
        case (ph)
          RISE: begin
            if (dly != '0) dly <= dly - 1'b1;
            else begin
              dly <= intv;
              if (rise_hit) begin
                duty <= duty_max;
                if (hold_hi == '0) begin ph <= FALL; dly <= '0; end
                else begin ph <= HOLD_HI; hcnt <= hold_hi; end
              end else duty <= sum[7:0];
            end
          end
          HOLD_HI: begin
            hcnt <= hcnt - 1'b1;
            if (hcnt == 1) begin ph <= FALL; dly <= '0; end
          end
          FALL: begin
            if (dly != '0) dly <= dly - 1'b1;
            else begin
              dly <= intv;
              if (fall_hit) begin
                duty <= duty_min;
                if (hold_lo == '0) begin ph <= RISE; dly <= '0; end
                else begin ph <= HOLD_LO; hcnt <= hold_lo; end
              end else duty <= duty - step[7:0];
            end
          end
          default: begin
            hcnt <= hcnt - 1'b1;
            if (hcnt == 1) begin ph <= RISE; dly <= '0; end
          end
        endcase
      end
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap) |-> cnt == 8'd0); // R1

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !led); // R3

  AST_PEAK_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == HOLD_HI && $past(ph) == RISE) |-> duty == $past(duty_max)); // R5

  AST_FLOOR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == HOLD_LO && $past(ph) == FALL) |-> duty == $past(duty_min)); // R6

  AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (duty != $past(duty)) |-> $past(wrap || !run)); // R9
endmodule

// File: tb/led_breath_pwm_tb.sv
module led_breath_pwm_tb;
  localparam int STEP_W = 8, INT_W = 3, HOLD_W = 4;

  logic clk = 0, rst_n = 0, tick = 0, run = 0, asym = 0;
  logic [1:0] size_sel = 0;
  logic [7:0] duty_min = 0, duty_max = 0;
  logic [HOLD_W-1:0] hold_hi = 0, hold_lo = 0;
  logic [8*STEP_W-1:0] step_tbl = 0;
  logic [8*INT_W-1:0] intv_tbl = 0;
  logic led;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  led_breath_pwm #(.STEP_W(STEP_W), .INT_W(INT_W), .HOLD_W(HOLD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .size_sel(size_sel),
    .duty_min(duty_min), .duty_max(duty_max), .hold_hi(hold_hi), .hold_lo(hold_lo),
    .step_tbl(step_tbl), .intv_tbl(intv_tbl), .asym(asym), .led(led));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: phases 0 rise, 1 hold high, 2 fall, 3 hold low
  int m_cnt = 0, m_duty = 0, m_ph = 0, m_dly = 0, m_hcnt = 0;
  bit model_on = 0;

  function automatic int top_of(input logic [1:0] s);
    return (s == 0) ? 255 : (s == 1) ? 127 : 63;
  endfunction

  function automatic int seg_of(input int d, input int ph);
    int sh, up;
    sh = (size_sel == 0) ? 5 : (size_sel == 1) ? 4 : 3;
    up = (d >> sh) & 7;
    return asym ? (((ph == 2) ? 4 : 0) + (up >> 1)) : up;
  endfunction

  task automatic model_wrap();
    int sg, st, iv;
    sg = seg_of(m_duty, m_ph);
    st = int'((step_tbl >> (sg*STEP_W)) & 64'hFF);
    iv = int'((intv_tbl >> (sg*INT_W)) & 64'h7);
    case (m_ph)
      0: if (m_dly != 0) m_dly--; else begin
           m_dly = iv;
           if (m_duty + st >= duty_max) begin
             m_duty = duty_max;
             if (hold_hi == 0) begin m_ph = 2; m_dly = 0; end
             else begin m_ph = 1; m_hcnt = hold_hi; end
           end else m_duty += st;
         end
      1: begin m_hcnt--; if (m_hcnt == 0) begin m_ph = 2; m_dly = 0; end end
      2: if (m_dly != 0) m_dly--; else begin
           m_dly = iv;
           if (m_duty <= duty_min + st) begin
             m_duty = duty_min;
             if (hold_lo == 0) begin m_ph = 0; m_dly = 0; end
             else begin m_ph = 3; m_hcnt = hold_lo; end
           end else m_duty -= st;
         end
      default: begin m_hcnt--; if (m_hcnt == 0) begin m_ph = 0; m_dly = 0; end end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n || !run) begin
      m_cnt = 0; m_duty = 0; m_ph = 0; m_dly = 0; m_hcnt = 0;
    end else if (tick) begin
      if (m_cnt == top_of(size_sel)) begin m_cnt = 0; model_wrap(); end
      else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (model_on)
      chk(led == (m_cnt < m_duty), asym ? "R2/R4/R5/R6/R8/R9" : "R2/R4/R5/R6/R7/R9",
          int'(led), int'(m_cnt < m_duty));
  end

  task automatic rand_cfg();
    int t;
    size_sel = 2'($urandom_range(0, 3));
    t = top_of(size_sel);
    asym = 1'($urandom_range(0, 1));
    duty_min = 8'($urandom_range(0, t / 3));
    duty_max = 8'($urandom_range(t / 2, t + 1 > 255 ? 255 : t + 1));
    hold_hi = HOLD_W'($urandom_range(0, 3));
    hold_lo = HOLD_W'($urandom_range(0, 3));
    for (int k = 0; k < 8; k++) begin
      step_tbl[k*STEP_W +: STEP_W] = STEP_W'($urandom_range(1, t / 4));
      intv_tbl[k*INT_W +: INT_W] = INT_W'($urandom_range(0, 2));
    end
  endtask

  task automatic measure_period(input logic [1:0] s, input int exp);
    int last, gap, n;
    bit prev;
    run = 0; size_sel = s; duty_min = 1; duty_max = 1; asym = 0;
    hold_hi = 15; hold_lo = 15; tick = 1;
    step_tbl = {8{8'h10}}; intv_tbl = '0;
    @(negedge clk); run = 1;
    repeat (3 * 256) @(negedge clk);
    prev = led; last = -1; gap = 0; n = 0;
    while (gap == 0 && n < 1000) begin
      @(negedge clk); n++;
      if (led && !prev) begin
        if (last >= 0) gap = n - last;
        last = n;
      end
      prev = led;
    end
    chk(gap == exp, "R1", gap, exp);
    run = 0;
  endtask

  initial begin
    void'($urandom(32'h1ED5));
    repeat (3) @(negedge clk);
    chk(led == 1'b0, "R3", int'(led), 0);
    rst_n = 1;
    @(negedge clk);
    chk(led == 1'b0, "R3", int'(led), 0);

    measure_period(2'd0, 256);
    measure_period(2'd1, 128);
    measure_period(2'd2, 64);
    measure_period(2'd3, 64);

    @(negedge clk);
    model_on = 1;
    // directed: one oversized step clamps straight to the ends
    size_sel = 2; asym = 1; duty_min = 5; duty_max = 60; hold_hi = 0; hold_lo = 2;
    step_tbl = {{4{8'd200}}, {4{8'd200}}}; intv_tbl = '0; tick = 1;
    @(negedge clk); run = 1;
    repeat (2000) @(negedge clk);
    run = 0; @(negedge clk);
    chk(led == 1'b0, "R3", int'(led), 0);

    for (int c = 0; c < 14; c++) begin
      rand_cfg();
      @(negedge clk); run = 1;
      for (int i = 0; i < 5000; i++) begin
        tick = ($urandom_range(0, 7) != 0);
        if (i == 2500 && c % 3 == 0) run = 0;
        else run = 1;
        @(negedge clk);
      end
      run = 0; @(negedge clk);
      chk(led == 1'b0, "R3", int'(led), 0);
    end
    model_on = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule